// File: doc/BRIEF.md
# Synthesizer Power-Up Programming Sequencer

This block programs an integer-N frequency synthesizer over a three-wire serial link made of a serial clock, a data line and a latch strobe. A single start pulse makes it send three 24-bit register words: first the reference-divider word, then the control word, then the feedback-divider word. The word contents come from elsewhere and sit on three input buses. The block reads each bus when it begins shifting that word.

When the control word is latched, the oscillator bias currents start to settle. The feedback word must not be latched before they have settled, because band selection would then fail. The block therefore holds back the third word for a settling time. Only the first programming after reset gets this wait, which is tracked by a sticky flag that only reset clears. A select input picks the minimum settling time: 5 ms by default, or 600 µs when a smaller noise capacitor is fitted. The delay counter is sized from the system clock frequency parameter and rounds up.

The serial clock comes from the system clock through a half-period divider. The block reports busy while it runs and gives a one-cycle done pulse once the last word is latched.

Top module: `synth_init_seq`

## Requirements
- R1: A start sends exactly three words in the fixed order refWord, ctrlWord, fbWord, and each word is followed by its own latch pulse.
- R2: Each word is 24 bits, sent MSB first, with one bit per serial clock rising edge. The data line changes only while the serial clock is low and holds steady while it is high. The serial clock idles low.
- R3: The latch line stays low while bits are shifted. It rises on the system clock edge where the last bit's serial clock falls, stays high for 2*SCK_HALF system cycles (one serial clock period), and the serial clock stays low during that time.
- R4: On the first programming after reset, the time from the control word's latch rise to the feedback word's latch rise is at least ceil(CLK_HZ*5 ms) system cycles when dlySel=0 at start, and at least ceil(CLK_HZ*600 µs) when dlySel=1.
- R5: No wait is inserted between the first and second words. Programming runs after the first one skip the settling wait, so the control-to-feedback latch spacing is only one word time.
- R6: busy goes high in the cycle after an accepted start and stays high until the sequence ends. done is high for exactly one cycle after the feedback word's latch falls, and busy is low in that cycle.
- R7: A start pulse seen while busy is high is ignored: no extra words and no extra done pulse follow.
- R8: The "already initialised" state is cleared only by reset, so the first programming after a new reset applies the settling wait again.
- R9: While in reset and right after it, sclk, sdata, le, busy and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled when idle |
| dlySel | input | 1 | Settling time select: 0 = 5 ms, 1 = 600 µs |
| refWord | input | 24 | Reference-divider register word |
| ctrlWord | input | 24 | Control register word |
| fbWord | input | 24 | Feedback-divider register word |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| le | output | 1 | Latch strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence ends |

## Verification
Two events can land in the same cycle: the done pulse that ends one sequence and a new start request. In the done cycle the control state is already idle, so that start must be accepted rather than dropped as if it arrived while busy. The bench waits for done, raises start in that same cycle, and then expects busy on the next cycle and a full new three-word sequence with no settling wait. A separate check sends a start in the middle of the settling wait and confirms that it leaves no trace in the word count or the done count.

// File: rtl/synth_init_pkg.sv
package synth_init_pkg;

  typedef enum logic [1:0] {
    SEL_REF  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_FB   = 2'd2
  } wordSel_e;

  typedef struct packed {
    logic     loadWord;
    wordSel_e wordSel;
    logic     startDelay;
    logic     longDelay;
  } seqStrobe_t;

endpackage

// File: rtl/synth_init_ctrl.sv
module synth_init_ctrl
  import synth_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       dlySel,
  input  logic       wordDone,
  input  logic       delayDone,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND_REF, ST_SEND_CTRL, ST_WAIT, ST_SEND_FB
  } state_e;

  state_e state, nextState;
  logic   initDone;
  logic   useLong;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        nextState     = ST_SEND_REF;
        strb.loadWord = 1'b1;
        strb.wordSel  = SEL_REF;
      end
      ST_SEND_REF: if (wordDone) begin
        nextState     = ST_SEND_CTRL;
        strb.loadWord = 1'b1;
        strb.wordSel  = SEL_CTRL;
      end
      ST_SEND_CTRL: if (wordDone) begin
        if (!initDone) begin
          nextState       = ST_WAIT;
          strb.startDelay = 1'b1;
          strb.longDelay  = useLong;
        end else begin
          nextState     = ST_SEND_FB;
          strb.loadWord = 1'b1;
          strb.wordSel  = SEL_FB;
        end
      end
      ST_WAIT: if (delayDone) begin
        nextState     = ST_SEND_FB;
        strb.loadWord = 1'b1;
        strb.wordSel  = SEL_FB;
      end
      ST_SEND_FB: if (wordDone) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      initDone <= 1'b0;
      useLong  <= 1'b1;
      done     <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == ST_SEND_FB) && wordDone;
      if ((state == ST_SEND_FB) && wordDone) initDone <= 1'b1;
      if ((state == ST_IDLE) && start) useLong <= !dlySel;
    end
  end

  assign busy = (state != ST_IDLE);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_wait_first_only_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !initDone);
  assert_order_ref_ctrl_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND_REF && nextState != ST_SEND_REF) |=> (state == ST_SEND_CTRL));
  assert_order_ctrl_fb_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND_CTRL && nextState != ST_SEND_CTRL) |=>
      (state == ST_WAIT || state == ST_SEND_FB));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !wordDone) |=> busy);

endmodule

// File: rtl/synth_init_datapath.sv
module synth_init_datapath
  import synth_init_pkg::*;
#(
  parameter int    WORD_W    = 24,
  parameter int    SCK_HALF  = 4,
  parameter longint CLK_HZ   = 100_000_000,
  parameter longint LONG_US  = 5000,
  parameter longint SHORT_US = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  input  logic [WORD_W-1:0] refWord,
  input  logic [WORD_W-1:0] ctrlWord,
  input  logic [WORD_W-1:0] fbWord,
  output logic              sclk,
  output logic              sdata,
  output logic              le,
  output logic              wordDone,
  output logic              delayDone
);

  localparam int     HALF_W    = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int     BIT_W     = $clog2(WORD_W + 1);
  localparam longint LONG_CYC  = (CLK_HZ * LONG_US + 64'd999_999) / 64'd1_000_000;
  localparam longint SHORT_CYC = (CLK_HZ * SHORT_US + 64'd999_999) / 64'd1_000_000;
  localparam int     DLY_W     = $clog2(LONG_CYC + 1);

  typedef enum logic [1:0] {SH_IDLE, SH_BITS, SH_LATCH} shStage_e;

  shStage_e          stage;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] selWord;
  logic [BIT_W-1:0]  bitsLeft;
  logic [HALF_W-1:0] halfCnt;
  logic              halfEnd;
  logic              latchHalf;
  logic              sclkR, leR;
  logic [DLY_W-1:0]  dlyCnt;
  logic              dlyRun;

  always_comb begin
    case (strb.wordSel)
      SEL_REF:  selWord = refWord;
      SEL_CTRL: selWord = ctrlWord;
      default:  selWord = fbWord;
    endcase
  end

  assign halfEnd = (halfCnt == HALF_W'(SCK_HALF - 1));

  // Serial shifter: each half period of the serial clock lasts SCK_HALF cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      stage     <= SH_IDLE;
      shiftReg  <= '0;
      bitsLeft  <= '0;
      halfCnt   <= '0;
      latchHalf <= 1'b0;
      sclkR     <= 1'b0;
      leR       <= 1'b0;
      wordDone  <= 1'b0;
    end else begin
      wordDone <= 1'b0;
      if (strb.loadWord) begin
        shiftReg  <= selWord;
        bitsLeft  <= BIT_W'(WORD_W);
        halfCnt   <= '0;
        sclkR     <= 1'b0;
        leR       <= 1'b0;
        latchHalf <= 1'b0;
        stage     <= SH_BITS;
      end else if (stage != SH_IDLE) begin
        if (!halfEnd) begin
          halfCnt <= halfCnt + 1'b1;
        end else begin
          halfCnt <= '0;
          case (stage)
            SH_BITS: begin
              if (!sclkR) begin
                sclkR <= 1'b1;
              end else begin
                sclkR    <= 1'b0;
                shiftReg <= shiftReg << 1;
                bitsLeft <= bitsLeft - 1'b1;
                if (bitsLeft == BIT_W'(1)) begin
                  stage     <= SH_LATCH;
                  leR       <= 1'b1;
                  latchHalf <= 1'b0;
                end
              end
            end
            SH_LATCH: begin
              if (latchHalf) begin
                leR      <= 1'b0;
                stage    <= SH_IDLE;
                wordDone <= 1'b1;
              end else begin
                latchHalf <= 1'b1;
              end
            end
            default: stage <= SH_IDLE;
          endcase
        end
      end
    end
  end

  // Settling delay counter
  always_ff @(posedge clk) begin
    if (rst) begin
      dlyCnt    <= '0;
      dlyRun    <= 1'b0;
      delayDone <= 1'b0;
    end else begin
      delayDone <= 1'b0;
      if (strb.startDelay) begin
        dlyCnt <= strb.longDelay ? DLY_W'(LONG_CYC) : DLY_W'(SHORT_CYC);
        dlyRun <= 1'b1;
      end else if (dlyRun) begin
        if (dlyCnt == DLY_W'(1)) begin
          dlyRun    <= 1'b0;
          delayDone <= 1'b1;
        end else begin
          dlyCnt <= dlyCnt - 1'b1;
        end
      end
    end
  end

  assign sclk  = sclkR;
  assign le    = leR;
  assign sdata = (stage == SH_IDLE) ? 1'b0 : shiftReg[WORD_W-1];

  assert_data_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (sclkR && $past(sclkR)) |-> (sdata == $past(sdata)));
  assert_le_sclk_low_R3: assert property (@(posedge clk) disable iff (rst)
    leR |-> !sclkR);
  assert_le_low_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (stage == SH_BITS) |-> !leR);
  assert_le_two_cycles_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(leR) |=> leR);
  assert_delay_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    dlyRun |-> (dlyCnt != '0));

endmodule

// File: rtl/synth_init_seq.sv
module synth_init_seq #(
  parameter int     WORD_W    = 24,
  parameter int     SCK_HALF  = 4,
  parameter longint CLK_HZ    = 100_000_000,
  parameter longint LONG_US   = 5000,
  parameter longint SHORT_US  = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dlySel,
  input  logic [WORD_W-1:0] refWord,
  input  logic [WORD_W-1:0] ctrlWord,
  input  logic [WORD_W-1:0] fbWord,
  output logic              sclk,
  output logic              sdata,
  output logic              le,
  output logic              busy,
  output logic              done
);

  synth_init_pkg::seqStrobe_t strb;
  logic wordDone;
  logic delayDone;

  synth_init_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dlySel    (dlySel),
    .wordDone  (wordDone),
    .delayDone (delayDone),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  synth_init_datapath #(
    .WORD_W   (WORD_W),
    .SCK_HALF (SCK_HALF),
    .CLK_HZ   (CLK_HZ),
    .LONG_US  (LONG_US),
    .SHORT_US (SHORT_US)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .refWord   (refWord),
    .ctrlWord  (ctrlWord),
    .fbWord    (fbWord),
    .sclk      (sclk),
    .sdata     (sdata),
    .le        (le),
    .wordDone  (wordDone),
    .delayDone (delayDone)
  );

  assert_busy_after_start_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

endmodule

// File: tb/sim_synth_init_seq.sv
module sim_synth_init_seq;

  localparam int     CLK_PERIOD = 10;
  localparam int     HALF       = 2;
  localparam longint HZ         = 4_000_000;
  localparam longint LONG_MIN   = 20000;  // ceil(4e6 * 5 ms)
  localparam longint SHORT_MIN  = 2400;   // ceil(4e6 * 600 us)
  localparam longint NO_WAIT_MAX = 300;
  localparam longint WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        dlySel = 1'b0;
  logic [23:0] refWord = '0, ctrlWord = '0, fbWord = '0;
  logic        sclk, sdata, le, busy, done;

  int checks = 0;
  int fails = 0;
  longint cyc = 0;

  // monitor state
  logic [23:0] cap = '0;
  int          bitCnt = 0;
  logic [23:0] wordLog [32];
  int          bitLog [32];
  longint      riseAt [32];
  int          wordCount = 0;
  int          doneCnt = 0;
  int          dataViol = 0;
  int          leViol = 0;
  longint      leStart = 0;
  logic        prevSclk = 1'b0, prevLe = 1'b0, prevData = 1'b0;

  synth_init_seq #(.WORD_W(24), .SCK_HALF(HALF), .CLK_HZ(HZ)) u0 (
    .clk(clk), .rst(rst), .start(start), .dlySel(dlySel),
    .refWord(refWord), .ctrlWord(ctrlWord), .fbWord(fbWord),
    .sclk(sclk), .sdata(sdata), .le(le), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst) begin
      bitCnt = 0;
    end else begin
      if (sclk && !prevSclk) begin
        cap = {cap[22:0], sdata};
        bitCnt++;
      end
      if (sclk && prevSclk && (sdata != prevData)) dataViol++;
      if (le && sclk) leViol++;
      if (le && !prevLe) begin
        if (wordCount < 32) begin
          wordLog[wordCount] = cap;
          bitLog[wordCount]  = bitCnt;
          riseAt[wordCount]  = cyc;
        end
        wordCount++;
        bitCnt  = 0;
        leStart = cyc;
      end
      if (!le && prevLe && (cyc - leStart != 2*HALF)) leViol++;
      if (done) doneCnt++;
    end
    prevSclk = sclk;
    prevLe   = le;
    prevData = sdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // returns at the negedge where done is seen high
  task automatic waitDone(input int limit, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic checkWords(input int base, input logic [23:0] a,
                            input logic [23:0] b, input logic [23:0] c);
    chk(wordLog[base]   == a, "R1", "first word",  longint'(wordLog[base]),   longint'(a));
    chk(wordLog[base+1] == b, "R1", "second word", longint'(wordLog[base+1]), longint'(b));
    chk(wordLog[base+2] == c, "R1", "third word",  longint'(wordLog[base+2]), longint'(c));
    for (int k = 0; k < 3; k++)
      chk(bitLog[base+k] == 24, "R2", "bits per word", bitLog[base+k], 24);
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!sclk && !sdata && !le && !busy && !done, "R9", "outputs in reset",
        {sclk, sdata, le, busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!sclk && !sdata && !le && !busy && !done, "R9", "outputs after reset",
        {sclk, sdata, le, busy, done}, 0);
  endtask

  task automatic testFirstLong();
    int base = wordCount;
    int d0;
    bit seen;
    refWord = 24'hA53C01; ctrlWord = 24'h4F8132; fbWord = 24'h1E0DC6;
    dlySel = 1'b0;
    pulseStart();
    chk(busy, "R6", "busy after start", busy, 1);
    // mid-wait start must be ignored
    repeat (3000) @(negedge clk);
    d0 = doneCnt;
    pulseStart();
    waitDone(30000, seen);
    chk(seen, "R6", "done seen", seen, 1);
    chk(!busy, "R6", "busy low in done cycle", busy, 0);
    @(negedge clk);
    chk(!done, "R6", "done one cycle", done, 0);
    checkWords(base, 24'hA53C01, 24'h4F8132, 24'h1E0DC6);
    chk(riseAt[base+2] - riseAt[base+1] >= LONG_MIN, "R4", "long settling gap",
        riseAt[base+2] - riseAt[base+1], LONG_MIN);
    chk(riseAt[base+1] - riseAt[base] <= NO_WAIT_MAX, "R5", "ref to ctrl gap",
        riseAt[base+1] - riseAt[base], NO_WAIT_MAX);
    repeat (500) @(negedge clk);
    chk(wordCount == base + 3, "R7", "word count after ignored start", wordCount, base + 3);
    chk(doneCnt == d0 + 1, "R7", "done count after ignored start", doneCnt, d0 + 1);
    chk(!busy && !sclk && !le, "R2", "idle lines low", {busy, sclk, le}, 0);
  endtask

  task automatic testReprogram();
    int base = wordCount;
    bit seen;
    refWord = 24'h800001; ctrlWord = 24'h7FFFFE; fbWord = 24'h5A5A5A;
    dlySel = 1'b0;
    pulseStart();
    waitDone(2000, seen);
    chk(seen, "R5", "reprogram finishes quickly", seen, 1);
    checkWords(base, 24'h800001, 24'h7FFFFE, 24'h5A5A5A);
    chk(riseAt[base+2] - riseAt[base+1] <= NO_WAIT_MAX, "R5", "no wait on reprogram",
        riseAt[base+2] - riseAt[base+1], NO_WAIT_MAX);
  endtask

  task automatic testStartInDoneCycle();
    int base = wordCount;
    bit seen;
    refWord = 24'h123456; ctrlWord = 24'hFEDCBA; fbWord = 24'h00F00F;
    pulseStart();
    waitDone(2000, seen);
    chk(seen, "R6", "done before back-to-back start", seen, 1);
    // raise start in the done cycle itself
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy, "R6", "start in done cycle accepted", busy, 1);
    waitDone(2000, seen);
    chk(seen, "R1", "back-to-back sequence done", seen, 1);
    chk(wordCount == base + 6, "R1", "six words sent", wordCount, base + 6);
    checkWords(base + 3, 24'h123456, 24'hFEDCBA, 24'h00F00F);
  endtask

  task automatic testResetShort();
    int base;
    bit seen;
    doReset();
    base = wordCount;
    refWord = 24'h0C0FFE; ctrlWord = 24'hB00B1E; fbWord = 24'h3C3C3C;
    dlySel = 1'b1;
    pulseStart();
    waitDone(6000, seen);
    chk(seen, "R8", "post-reset run done", seen, 1);
    checkWords(base, 24'h0C0FFE, 24'hB00B1E, 24'h3C3C3C);
    chk(riseAt[base+2] - riseAt[base+1] >= SHORT_MIN, "R8", "wait reapplied after reset",
        riseAt[base+2] - riseAt[base+1], SHORT_MIN);
    chk(riseAt[base+2] - riseAt[base+1] < LONG_MIN, "R4", "short settling selected",
        riseAt[base+2] - riseAt[base+1], SHORT_MIN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testFirstLong();
    testReprogram();
    testStartInDoneCycle();
    testResetShort();
    chk(dataViol == 0, "R2", "data changes while sclk high", dataViol, 0);
    chk(leViol == 0, "R3", "latch width or sclk during latch", leViol, 0);
    summary();
  end

endmodule